// File: doc/BRIEF.md
# Bus-Conflict Instruction Cache

This block sits beside the instruction sequencer of a processor whose program memory is shared between instruction fetch and one of the two data paths. Each cycle the sequencer may present a fetch address. With it comes a flag that says whether the instruction ahead is using the program-memory bus for a data transfer in that same cycle. Without a conflict, the fetch goes straight to memory: the block neither answers nor records anything. With a conflict, the block looks the address up. On a hit it supplies the stored 48-bit word, so the fetch and both data transfers go ahead together. On a miss it raises a stall for one cycle. In that cycle the bus is free, the word is read from memory and handed back on the fill port, and the block installs it.

The store has 32 entries, arranged as 16 sets of two ways. The low four address bits select the set and the remaining bits form the tag. Within a set, a single bit per set marks the least recently used way. A loop that holds more conflicting instructions than one set can keep will evict its own entries on every pass, so it gains nothing. A global invalidate empties the store in one cycle.

Top module: `busconf_icache`

## Requirements
- R1: After reset, `hit_o` and `stall_o` are 0, `word_o` is 0, and no entry is valid, so the first conflicting fetch of any address misses.
- R2: A conflicting fetch that misses drives `stall_o` high in the following cycle for exactly one cycle, with `fill_addr_o` equal to the fetch address. No lookup is accepted while `stall_o` is high.
- R3: `fill_valid_i` high in the cycle `stall_o` is high installs `fill_word_i`. A later conflicting fetch of that address gives `hit_o` = 1, `stall_o` = 0 and `word_o` = the installed word, one cycle after the fetch.
- R4: A fetch with `pm_conflict_i` = 0 gives `hit_o` = 0 and `stall_o` = 0 one cycle later, even for a cached address, and allocates no entry.
- R5: A fetch with `pm_conflict_i` = 0 leaves the replacement state of every set unchanged.
- R6: A conflicting hit marks the hit way as most recently used. An install uses an invalid way if one exists (way 0 first), and otherwise the least recently used way, then marks that way most recently used.
- R7: The set is `fetch_addr_i[3:0]` and the tag is the remaining upper bits. All 32 entries (two tags in each of the 16 sets) can be held at once.
- R8: Three conflicting addresses that share one set, fetched in rotation, miss on every fetch.
- R9: `invalidate_i` clears every valid bit in one cycle. A conflicting fetch presented in the same cycle as the invalidate is not looked up.
- R10: `fill_valid_i` while `stall_o` is low has no effect.
- R11: With `fetch_valid_i` = 0, `hit_o` and `stall_o` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | A fetch address is presented |
| fetch_addr_i | input | ADDR_W | Fetch address |
| pm_conflict_i | input | 1 | Preceding instruction holds the program-memory bus for data |
| fill_valid_i | input | 1 | Memory word for the stalled fetch is on `fill_word_i` |
| fill_word_i | input | WORD_W | Instruction word read during the stall cycle |
| invalidate_i | input | 1 | Clear all entries |
| hit_o | output | 1 | Cached word supplied on `word_o` (registered) |
| stall_o | output | 1 | Conflict miss, one-cycle stall (registered) |
| word_o | output | WORD_W | Cached instruction word, 0 when `hit_o` is low |
| fill_addr_o | output | ADDR_W | Address to read from memory during the stall |

## Verification
On every cycle, the assertions check the following: a hit and a stall never occur together; a stall lasts one cycle and names the fetched address; a fetch without a conflict stays silent and leaves the replacement bits alone; an invalidate is never followed by a hit; and no address matches in two ways at once. The bench scenarios are the only evidence for the rest. Those are installs that return the right word, victims chosen in least-recently-used order, thrashing when three addresses share one set, a full store of 32 entries, and fills with no pending stall being ignored.

// File: rtl/bcic_pkg.sv
package bcic_pkg;
  // Two ways per set; the replacement bit per set assumes exactly two.
  localparam int NUM_WAYS = 2;
  localparam int WAY_W    = 1;
endpackage

// File: rtl/bcic_tag_store.sv
module bcic_tag_store
  import bcic_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 12,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear_i,
  input  logic [IDX_W-1:0]    lk_idx_i,
  input  logic [TAG_W-1:0]    lk_tag_i,
  input  logic                wr_en_i,
  input  logic [WAY_W-1:0]    wr_way_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [TAG_W-1:0]    wr_tag_i,
  output logic [NUM_WAYS-1:0] way_hit_o,
  output logic [NUM_WAYS-1:0] way_valid_o
);

  logic [TAG_W-1:0] tag_q   [NUM_WAYS][SETS];
  logic [SETS-1:0]  valid_q [NUM_WAYS];

  // Valid bits: flops so that a single-cycle global clear is possible.
  always_ff @(posedge clk) begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (rst || clear_i) begin
        valid_q[w] <= '0;
      end else if (wr_en_i && (wr_way_i == WAY_W'(w))) begin
        valid_q[w][wr_idx_i] <= 1'b1;
      end
    end
  end

  // Tags need no reset; they are qualified by the valid bits.
  always_ff @(posedge clk) begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (wr_en_i && (wr_way_i == WAY_W'(w))) begin
        tag_q[w][wr_idx_i] <= wr_tag_i;
      end
    end
  end

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
    assign way_valid_o[g] = valid_q[g][lk_idx_i];
    assign way_hit_o[g]   = valid_q[g][lk_idx_i] && (tag_q[g][lk_idx_i] == lk_tag_i);
  end

  AST_WAY_HIT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit_o)); // R6

endmodule

// File: rtl/bcic_way_ram.sv
module bcic_way_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 48,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (re_i) begin
      rdata_o <= mem[raddr_i];
    end
  end

endmodule

// File: rtl/bcic_lru.sv
module bcic_lru
  import bcic_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [WAY_W-1:0] used_way_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WAY_W-1:0] victim_o,
  output logic [SETS-1:0]  lru_o
);

  logic [SETS-1:0] lru_q;

  // Each bit names the way to replace next in its set.
  always_ff @(posedge clk) begin
    if (rst) begin
      lru_q <= '0;
    end else if (upd_i) begin
      lru_q[upd_idx_i] <= ~used_way_i;
    end
  end

  assign victim_o = lru_q[rd_idx_i];
  assign lru_o    = lru_q;

  AST_MRU_NOT_VICTIM: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> (lru_q[$past(upd_idx_i)] != $past(used_way_i))); // R6

endmodule

// File: rtl/busconf_icache.sv
module busconf_icache
  import bcic_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 48,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              pm_conflict_i,
  input  logic              fill_valid_i,
  input  logic [WORD_W-1:0] fill_word_i,
  input  logic              invalidate_i,
  output logic              hit_o,
  output logic              stall_o,
  output logic [WORD_W-1:0] word_o,
  output logic [ADDR_W-1:0] fill_addr_o
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]    lk_idx;
  logic [TAG_W-1:0]    lk_tag;
  logic                lk_en;
  logic [NUM_WAYS-1:0] way_hit;
  logic [NUM_WAYS-1:0] way_valid;
  logic                any_hit;
  logic [WAY_W-1:0]    hit_way;
  logic [WAY_W-1:0]    lru_victim;
  logic [WAY_W-1:0]    victim;
  logic [SETS-1:0]     lru_vec;

  logic                hit_q;
  logic                stall_q;
  logic [WAY_W-1:0]    hit_way_q;
  logic [WAY_W-1:0]    victim_q;
  logic [ADDR_W-1:0]   miss_addr_q;

  logic                install;
  logic [IDX_W-1:0]    ins_idx;
  logic [TAG_W-1:0]    ins_tag;
  logic                lru_upd;
  logic [IDX_W-1:0]    lru_idx;
  logic [WAY_W-1:0]    lru_way;
  logic [WORD_W-1:0]   rd_word [NUM_WAYS];

  assign lk_idx  = fetch_addr_i[IDX_W-1:0];
  assign lk_tag  = fetch_addr_i[ADDR_W-1:IDX_W];
  // Only conflicting fetches look up; none while a stall is open or on invalidate.
  assign lk_en   = fetch_valid_i && pm_conflict_i && !stall_q && !invalidate_i;
  assign any_hit = |way_hit;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (way_hit[w]) hit_way = WAY_W'(w);
    end
  end

  // Fill an empty way first, otherwise the least recently used one.
  always_comb begin
    if (!way_valid[0])      victim = WAY_W'(0);
    else if (!way_valid[1]) victim = WAY_W'(1);
    else                    victim = lru_victim;
  end

  assign ins_idx = miss_addr_q[IDX_W-1:0];
  assign ins_tag = miss_addr_q[ADDR_W-1:IDX_W];
  assign install = fill_valid_i && stall_q && !invalidate_i;

  assign lru_upd = install || (lk_en && any_hit);
  assign lru_idx = install ? ins_idx  : lk_idx;
  assign lru_way = install ? victim_q : hit_way;

  bcic_tag_store #(
    .SETS  (SETS),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (invalidate_i),
    .lk_idx_i    (lk_idx),
    .lk_tag_i    (lk_tag),
    .wr_en_i     (install),
    .wr_way_i    (victim_q),
    .wr_idx_i    (ins_idx),
    .wr_tag_i    (ins_tag),
    .way_hit_o   (way_hit),
    .way_valid_o (way_valid)
  );

  bcic_lru #(
    .SETS (SETS)
  ) u_lru (
    .clk        (clk),
    .rst        (rst),
    .upd_i      (lru_upd),
    .upd_idx_i  (lru_idx),
    .used_way_i (lru_way),
    .rd_idx_i   (lk_idx),
    .victim_o   (lru_victim),
    .lru_o      (lru_vec)
  );

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    bcic_way_ram #(
      .DEPTH (SETS),
      .WIDTH (WORD_W)
    ) u_ram (
      .clk     (clk),
      .we_i    (install && (victim_q == WAY_W'(g))),
      .waddr_i (ins_idx),
      .wdata_i (fill_word_i),
      .re_i    (lk_en),
      .raddr_i (lk_idx),
      .rdata_o (rd_word[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q       <= 1'b0;
      stall_q     <= 1'b0;
      hit_way_q   <= '0;
      victim_q    <= '0;
      miss_addr_q <= '0;
    end else begin
      hit_q   <= lk_en && any_hit;
      stall_q <= lk_en && !any_hit;
      if (lk_en) begin
        hit_way_q   <= hit_way;
        victim_q    <= victim;
        miss_addr_q <= fetch_addr_i;
      end
    end
  end

  assign hit_o       = hit_q;
  assign stall_o     = stall_q;
  assign word_o      = hit_q ? rd_word[hit_way_q] : '0;
  assign fill_addr_o = miss_addr_q;

  AST_HIT_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(hit_o && stall_o)); // R2
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> !stall_o); // R2
  AST_STALL_ADDR: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> (fill_addr_o == $past(fetch_addr_i))); // R2
  AST_NOCONF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid_i && !pm_conflict_i) |=> (!hit_o && !stall_o)); // R4
  AST_NOCONF_LRU_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid_i && !pm_conflict_i && !(fill_valid_i && stall_o)) |=> $stable(lru_vec)); // R5
  AST_INVAL_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    invalidate_i |=> !hit_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid_i |=> (!hit_o && !stall_o)); // R11

endmodule

// File: tb/busconf_icache_tb.sv
`timescale 1ns/1ps
module busconf_icache_tb;

  localparam int ADDR_W = 16;
  localparam int WORD_W = 48;
  localparam int NVEC   = 21;

  localparam logic [3:0] OP_IDLE  = 4'd0;
  localparam logic [3:0] OP_CONF  = 4'd1;
  localparam logic [3:0] OP_PLAIN = 4'd2;
  localparam logic [3:0] OP_INV   = 4'd3;
  localparam logic [3:0] OP_STRAY = 4'd4;

  logic              clk = 1'b0;
  logic              rst;
  logic              fetch_valid_i;
  logic [ADDR_W-1:0] fetch_addr_i;
  logic              pm_conflict_i;
  logic              fill_valid_i;
  logic [WORD_W-1:0] fill_word_i;
  logic              invalidate_i;
  logic              hit_o;
  logic              stall_o;
  logic [WORD_W-1:0] word_o;
  logic [ADDR_W-1:0] fill_addr_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  busconf_icache u_dut (
    .clk           (clk),
    .rst           (rst),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .pm_conflict_i (pm_conflict_i),
    .fill_valid_i  (fill_valid_i),
    .fill_word_i   (fill_word_i),
    .invalidate_i  (invalidate_i),
    .hit_o         (hit_o),
    .stall_o       (stall_o),
    .word_o        (word_o),
    .fill_addr_o   (fill_addr_o)
  );

  // {op, req, exp_hit, exp_stall, pad, addr}; set = addr[3:0]
  localparam logic [27:0] VEC [NVEC] = '{
    {OP_CONF,  4'd1,  1'b0, 1'b1, 2'b0, 16'h0013}, // R1 empty store misses
    {OP_CONF,  4'd3,  1'b1, 1'b0, 2'b0, 16'h0013}, // R3 installed word served
    {OP_PLAIN, 4'd4,  1'b0, 1'b0, 2'b0, 16'h0013}, // R4 bypass even when cached
    {OP_CONF,  4'd6,  1'b0, 1'b1, 2'b0, 16'h0123}, // R6 second way of set 3
    {OP_CONF,  4'd3,  1'b1, 1'b0, 2'b0, 16'h0123}, // R3
    {OP_CONF,  4'd6,  1'b1, 1'b0, 2'b0, 16'h0013}, // R6 A becomes MRU
    {OP_PLAIN, 4'd5,  1'b0, 1'b0, 2'b0, 16'h0123}, // R5 must not touch LRU
    {OP_CONF,  4'd6,  1'b0, 1'b1, 2'b0, 16'h0453}, // R6 evicts B
    {OP_CONF,  4'd5,  1'b1, 1'b0, 2'b0, 16'h0013}, // R5 A survived
    {OP_CONF,  4'd6,  1'b0, 1'b1, 2'b0, 16'h0123}, // R6 B was evicted
    {OP_CONF,  4'd8,  1'b0, 1'b1, 2'b0, 16'h0453}, // R8 rotation thrash
    {OP_CONF,  4'd8,  1'b0, 1'b1, 2'b0, 16'h0013}, // R8
    {OP_CONF,  4'd8,  1'b0, 1'b1, 2'b0, 16'h0123}, // R8
    {OP_PLAIN, 4'd4,  1'b0, 1'b0, 2'b0, 16'h0777}, // R4 no allocation
    {OP_CONF,  4'd4,  1'b0, 1'b1, 2'b0, 16'h0777}, // R4 still a miss
    {OP_STRAY, 4'd10, 1'b0, 1'b0, 2'b0, 16'h0088}, // R10 fill without stall
    {OP_CONF,  4'd10, 1'b0, 1'b1, 2'b0, 16'h0088}, // R10 nothing installed
    {OP_CONF,  4'd3,  1'b1, 1'b0, 2'b0, 16'h0088}, // R3
    {OP_INV,   4'd9,  1'b0, 1'b0, 2'b0, 16'h0088}, // R9 clear all
    {OP_CONF,  4'd9,  1'b0, 1'b1, 2'b0, 16'h0088}, // R9 miss after clear
    {OP_IDLE,  4'd11, 1'b0, 1'b0, 2'b0, 16'h0088}  // R11 no fetch
  };

  function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return {16'hC0DE, a, ~a};
  endfunction

  task automatic check(input int req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    fetch_valid_i = 1'b0;
    pm_conflict_i = 1'b0;
    fill_valid_i  = 1'b0;
    invalidate_i  = 1'b0;
  endtask

  task automatic run_op(input logic [3:0] op, input int req,
                        input logic [ADDR_W-1:0] a, input logic eh, input logic es);
    @(negedge clk);
    clear_inputs();
    fetch_addr_i = a;
    case (op)
      OP_CONF:  begin fetch_valid_i = 1'b1; pm_conflict_i = 1'b1; end
      OP_PLAIN: begin fetch_valid_i = 1'b1; pm_conflict_i = 1'b0; end
      OP_INV:   invalidate_i = 1'b1;
      OP_STRAY: begin fill_valid_i = 1'b1; fill_word_i = word_of(a); end
      default:  pm_conflict_i = 1'b1;
    endcase
    @(negedge clk);
    clear_inputs();
    check(req, "hit_o", 64'(hit_o), 64'(eh));
    check(req, "stall_o", 64'(stall_o), 64'(es));
    check(req, "word_o", 64'(word_o), eh ? 64'(word_of(a)) : 64'd0);
    if (stall_o && op == OP_CONF) begin
      check(2, "fill_addr_o", 64'(fill_addr_o), 64'(a)); // R2
      fill_valid_i = 1'b1;
      fill_word_i  = word_of(a);
      @(negedge clk);
      fill_valid_i = 1'b0;
      check(2, "stall_o one cycle", 64'(stall_o), 64'd0); // R2
    end
  endtask

  initial begin
    rst = 1'b1;
    clear_inputs();
    fetch_addr_i = '0;
    fill_word_i  = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, "reset hit_o", 64'(hit_o), 64'd0);
    check(1, "reset stall_o", 64'(stall_o), 64'd0);
    check(1, "reset word_o", 64'(word_o), 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][27:24], int'(VEC[i][23:20]), VEC[i][15:0], VEC[i][19], VEC[i][18]);
    end

    // R7 full capacity: two tags in every set
    run_op(OP_INV, 9, 16'h0, 1'b0, 1'b0);
    for (int t = 1; t <= 2; t++) begin
      for (int s = 0; s < 16; s++) begin
        run_op(OP_CONF, 7, {12'(t * 3), 4'(s)}, 1'b0, 1'b1);
      end
    end
    for (int t = 1; t <= 2; t++) begin
      for (int s = 0; s < 16; s++) begin
        run_op(OP_CONF, 7, {12'(t * 3), 4'(s)}, 1'b1, 1'b0);
      end
    end

    // R1 reset empties the store
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(1, "mid reset hit_o", 64'(hit_o), 64'd0);
    rst = 1'b0;
    run_op(OP_CONF, 1, {12'd3, 4'd5}, 1'b0, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule